// File: doc/BRIEF.md
# Radio-State Driven GPIO Bank

This block owns a narrow bank of general-purpose pins whose output levels can follow the radio's activity without software in the loop. Every pin is switched, one bit at a time, between a manual output register and automatic selection. Under automatic selection the pin takes its level from one of four value registers. The live transmit and receive flags pick which of the four applies, so an external amplifier or mixer switch can toggle together with the radio enables.

Software programs seven registers over a small synchronous register bus. Every write carries a mask as well as a value, so each access touches only the chosen bits. The block registers the pad outputs and the output enables. It also offers a read-only view of the pad inputs through a two-stage synchronizer.

Top module: `gpio_atr_bank`

## Requirements
- R1: While rst_ni is low and after it is released, every register reads 0, pad_out_o is 0 and pad_oe_o is 0.
- R2: A write (wr_en_i high at a rising edge) to address 0..6 sets register bit b to wdata_i[b] where wmask_i[b] is 1. Bits whose mask bit is 0 keep their old value.
- R3: The register at address 0 is the mode word. A pin whose mode bit is 0 drives the manual output register (address 2) on pad_out_o.
- R4: The register at address 1 is the direction word, with 1 meaning output. pad_oe_o equals the direction word and changes on the edge that writes it.
- R5: A pin whose mode bit is 1 drives a bit of a value register. The radio state {tx_active_i, rx_active_i} selects that register: 00 selects address 3 (idle), 01 selects address 4 (receive), 10 selects address 5 (transmit) and 11 selects address 6 (full duplex).
- R6: A change of the transmit or receive flag shows on pad_out_o exactly one clock edge later.
- R7: When a write and a radio state change land on the same edge, pad_out_o after that edge is computed from the newly written register contents.
- R8: Address 7 reads back one value per pin. An input pin (direction bit 0) returns pad_in_i delayed by two clock edges. An output pin returns the level it currently drives on pad_out_o.
- R9: Writes to address 7 change no register and no output.
- R10: rdata_o shows the register selected by addr_i combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for both read and write |
| wdata_i | input | WIDTH | Write value |
| wmask_i | input | WIDTH | Per-bit write enable |
| rdata_o | output | WIDTH | Read data for addr_i |
| tx_active_i | input | 1 | Radio is transmitting |
| rx_active_i | input | 1 | Radio is receiving |
| pad_in_i | input | WIDTH | Asynchronous pad input levels |
| pad_out_o | output | WIDTH | Registered pad output levels |
| pad_oe_o | output | WIDTH | Registered pad output enables |

## Verification
The assertions assume that wr_en_i, addr_i, the data and mask words and both radio flags are synchronous to clk_i and stable around each rising edge. Only pad_in_i may change at any time. The bench drives every input just after a falling edge and compares just before the next falling edge, so each rising edge sees settled values. It applies writes together with state changes to exercise R7. Pad input toggles cover the two-edge readback delay.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned N_STATE = 4;
  localparam int unsigned N_REG   = (2 ** ADDR_W) - 1;  // last address is readback

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE = 3'd0,
    REG_DIR  = 3'd1,
    REG_MAN  = 3'd2,
    REG_IDLE = 3'd3,
    REG_RXO  = 3'd4,
    REG_TXO  = 3'd5,
    REG_FDX  = 3'd6,
    REG_RDBK = 3'd7
  } reg_addr_e;

  localparam int unsigned ATR_BASE = int'(REG_IDLE);
endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
  import gpio_atr_pkg::*;
#(
  parameter int unsigned WIDTH = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WIDTH-1:0]             wdata_i,
  input  logic [WIDTH-1:0]             wmask_i,
  output logic [N_REG-1:0][WIDTH-1:0]  rf_q_o,
  output logic [N_REG-1:0][WIDTH-1:0]  rf_d_o
);
  logic [N_REG-1:0][WIDTH-1:0] rf_q;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (addr_i == ADDR_W'(i));
    assign rf_d_o[i] = hit ? ((rf_q[i] & ~wmask_i) | (wdata_i & wmask_i)) : rf_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rf_q[i] <= '0;
      else         rf_q[i] <= rf_d_o[i];
    end

    // R2: unmasked bits keep their value across a write
    a_r2_mask_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> ((rf_q[i] ^ $past(rf_q[i])) & ~$past(wmask_i)) == '0);
  end

  assign rf_q_o = rf_q;

  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rf_q));
  a_r9_rdbk_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_RDBK) |=> $stable(rf_q));
endmodule

// File: rtl/gpio_atr_sel.sv
module gpio_atr_sel
  import gpio_atr_pkg::*;
#(
  parameter int unsigned WIDTH = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    state_i,
  input  logic [WIDTH-1:0]              mode_i,
  input  logic [WIDTH-1:0]              dir_i,
  input  logic [WIDTH-1:0]              man_i,
  input  logic [N_STATE-1:0][WIDTH-1:0] atr_i,
  output logic [WIDTH-1:0]              pad_out_o,
  output logic [WIDTH-1:0]              pad_oe_o
);
  logic [WIDTH-1:0] auto_val, out_nxt;

  assign auto_val = atr_i[state_i];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign out_nxt[b] = mode_i[b] ? auto_val[b] : man_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_out_o <= '0;
      pad_oe_o  <= '0;
    end else begin
      pad_out_o <= out_nxt;
      pad_oe_o  <= dir_i;
    end
  end
endmodule

// File: rtl/gpio_atr_sync.sv
module gpio_atr_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/gpio_atr_bank.sv
module gpio_atr_bank
  import gpio_atr_pkg::*;
#(
  parameter int unsigned WIDTH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  wmask_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic              tx_active_i,
  input  logic              rx_active_i,
  input  logic [WIDTH-1:0]  pad_in_i,
  output logic [WIDTH-1:0]  pad_out_o,
  output logic [WIDTH-1:0]  pad_oe_o
);
  localparam int unsigned ATR_TOP = ATR_BASE + N_STATE - 1;

  logic [N_REG-1:0][WIDTH-1:0]      rf_q, rf_d;
  logic [N_STATE-1:0][WIDTH-1:0]    atr_q;
  logic [(2**ADDR_W)-1:0][WIDTH-1:0] rd_view;
  logic [WIDTH-1:0]                 pin_sync, rdbk;
  logic [1:0]                       state;

  assign state = {tx_active_i, rx_active_i};

  gpio_atr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wmask_i (wmask_i),
    .rf_q_o  (rf_q),
    .rf_d_o  (rf_d)
  );

  // next-state register values feed the output stage (same-edge writes win)
  gpio_atr_sel #(.WIDTH(WIDTH)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .mode_i    (rf_d[REG_MODE]),
    .dir_i     (rf_d[REG_DIR]),
    .man_i     (rf_d[REG_MAN]),
    .atr_i     (rf_d[ATR_TOP:ATR_BASE]),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  gpio_atr_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  assign atr_q   = rf_q[ATR_TOP:ATR_BASE];
  assign rdbk    = (rf_q[REG_DIR] & pad_out_o) | (~rf_q[REG_DIR] & pin_sync);
  assign rd_view = {rdbk, rf_q};
  assign rdata_o = rd_view[addr_i];

  a_r4_oe_tracks_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o == rf_q[REG_DIR]);
  a_r3_manual_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~rf_q[REG_MODE]) & (pad_out_o ^ rf_q[REG_MAN])) == '0);

  for (genvar s = 0; s < N_STATE; s++) begin : g_chk
    a_r5_auto_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == 2'(s)) |=> ((rf_q[REG_MODE] & (pad_out_o ^ atr_q[s])) == '0));
  end
endmodule

// File: tb/sim_gpio_atr_bank.sv
module sim_gpio_atr_bank;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0, wmask = '0, pad_in = '0;
  logic         tx = 1'b0, rx = 1'b0;
  logic [W-1:0] rdata, pad_out, pad_oe;

  int n_chk = 0, n_fail = 0;

  // reference state
  logic [W-1:0] m_reg [8];
  logic [W-1:0] m_out = '0, m_oe = '0, m_s1 = '0, m_s2 = '0;

  always #2 clk = ~clk;

  gpio_atr_bank #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .wmask_i(wmask), .rdata_o(rdata),
    .tx_active_i(tx), .rx_active_i(rx), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_rd();
    if (addr == 3'd7) return (m_reg[1] & m_out) | (~m_reg[1] & m_s2);
    return m_reg[addr];
  endfunction

  task automatic step(string tag, bit we, int a, int d, int m, bit t, bit r, int pin);
    logic [W-1:0] sel;
    wr_en = we; addr = 3'(a); wdata = W'(d); wmask = W'(m); tx = t; rx = r; pad_in = W'(pin);
    @(posedge clk);
    if (we && a < 7) m_reg[a] = (m_reg[a] & ~W'(m)) | (W'(d) & W'(m));
    sel   = m_reg[3 + {t, r}];
    m_out = (m_reg[0] & sel) | (~m_reg[0] & m_reg[2]);
    m_oe  = m_reg[1];
    m_s2  = m_s1;
    m_s1  = W'(pin);
    @(negedge clk);
    chk(tag, "pad_out", pad_out, m_out);
    chk(tag, "pad_oe", pad_oe, m_oe);
    chk(tag, "rdata", rdata, exp_rd());
  endtask

  task automatic idle(string tag, int a, bit t, bit r, int pin);
    step(tag, 1'b0, a, 0, 0, t, r, pin);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    #1;
    chk("R1", "pad_out in reset", pad_out, '0);
    chk("R1", "pad_oe in reset", pad_oe, '0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) idle("R1", a, 0, 0, 0);

    // R2 masked writes on the mode word, R10 combinational read
    step("R2", 1, 0, 'h3F, 'h0F, 0, 0, 0);
    step("R2", 1, 0, 'h00, 'h03, 0, 0, 0);
    idle("R10", 0, 0, 0, 0);
    step("R2", 1, 2, 'h15, 'h3F, 0, 0, 0);
    step("R2", 1, 2, 'h2A, 'h30, 0, 0, 0);
    idle("R10", 2, 0, 0, 0);

    // R9 writes to readback address ignored
    step("R9", 1, 7, 'h3F, 'h3F, 0, 0, 0);
    for (int a = 0; a < 7; a++) idle("R9", a, 0, 0, 0);

    // R4 direction
    step("R4", 1, 1, 'h2A, 'h3F, 0, 0, 0);
    idle("R4", 1, 0, 0, 0);
    step("R4", 1, 1, 'h15, 'h1F, 0, 0, 0);

    // R5 value registers, then walk all states
    step("R5", 1, 3, 'h05, 'h3F, 0, 0, 0);
    step("R5", 1, 4, 'h0A, 'h3F, 0, 0, 0);
    step("R5", 1, 5, 'h30, 'h3F, 0, 0, 0);
    step("R5", 1, 6, 'h3F, 'h3F, 0, 0, 0);
    step("R3", 1, 0, 'h00, 'h3F, 1, 1, 0);
    idle("R3", 2, 1, 0, 0);
    step("R5", 1, 0, 'h3F, 'h3F, 0, 0, 0);
    idle("R5", 3, 0, 1, 0);
    idle("R6", 4, 1, 0, 0);
    idle("R6", 5, 1, 1, 0);
    idle("R6", 6, 0, 0, 0);
    idle("R6", 0, 1, 0, 0);
    // R3 partial mode: low bits manual
    step("R3", 1, 0, 'h30, 'h3F, 0, 1, 0);
    idle("R3", 0, 1, 1, 0);

    // R7 write and state change on the same edge
    step("R7", 1, 5, 'h0C, 'h3F, 1, 0, 0);
    step("R7", 1, 6, 'h21, 'h0F, 1, 1, 0);
    step("R7", 1, 0, 'h3F, 'h3F, 0, 0, 0);

    // R8 readback of inputs and outputs
    step("R8", 1, 1, 'h0F, 'h3F, 0, 0, 'h00);
    idle("R8", 7, 1, 0, 'h3F);
    idle("R8", 7, 1, 0, 'h30);
    idle("R8", 7, 0, 1, 'h10);
    idle("R8", 7, 0, 1, 'h20);
    idle("R8", 7, 1, 1, 'h00);
    idle("R8", 7, 1, 1, 'h00);

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int a;
      a = int'($urandom_range(0, 7));
      step("R7", 1'($urandom_range(0, 1)), a, int'($urandom_range(0, 63)),
           int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), int'($urandom_range(0, 63)));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule